// File: doc/BRIEF.md
# Serial Step-Attenuator Load Engine

This block programs one stage of a bank of digital step attenuators through a three-wire serial link. All stages share a single data wire and a single shift-clock wire. Each stage has its own latch strobe. A request names a channel, a stage and an attenuation in quarter-dB units. The engine checks the request and turns the value into a 6-bit code in half-dB units. It shifts the code out most significant bit first, and then strobes the latch of the addressed stage only.

Software or a sequencer offers a request for one cycle while `busy` is low. A one-cycle `done` pulse reports the outcome in `err_code`. Every high and low phase of the shift clock lasts a programmable number of system clocks. The latch strobe lasts the same number of clocks. A floor derived from the clock period keeps every pulse at 30 ns or longer.

Top module: `atten_loader`

## Requirements
- R1: While reset is asserted and after it is released, `ser_data`, `ser_clk`, every `latch_en` bit, `busy` and `done` are low.
- R2: The code shifted out is (req_qdb / 4) * 2, a 6-bit word in half-dB units whose bit 0 (the half-dB bit) is always 0. It is sent bit 5 first and bit 0 last.
- R3: For each bit, `ser_data` takes the bit value before `ser_clk` rises, and it holds that value for as long as `ser_clk` stays high. Exactly six rising edges of `ser_clk` occur per accepted write.
- R4: The phase length P is the larger of `div_cfg` and MIN_CYC, where MIN_CYC = ceil(30 ns / clock period) (8 at a 4 ns clock). The data setup phase before each rise lasts P clocks, each `ser_clk` high phase lasts P clocks, and the latch strobe stays high for P clocks.
- R5: All `latch_en` bits stay low while bits are shifted. After the sixth bit, exactly one bit pulses high once, at index (req_chan-1)*NUM_ST + (req_stage-1).
- R6: Channel 0, a channel above NUM_CH (8), stage 0 or a stage above NUM_ST (2) is rejected. The block gives `done` with `err_code` = 2'b01 one cycle after the request, raises no clock or latch pulse, and does not raise `busy`.
- R7: A request with req_qdb / 4 greater than 31 is rejected with `err_code` = 2'b10 and no pulses. A bad index takes precedence over a bad range.
- R8: `busy` rises in the cycle after a valid request is accepted and stays high until the latch strobe has returned low. A request offered while `busy` is high is ignored.
- R9: `done` is a one-cycle pulse. For a successful write it comes in the cycle the latch strobe falls, with `err_code` = 2'b00 and `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_cfg | input | 8 | Requested phase length in clocks, sampled at accept |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_chan | input | 4 | Channel number, valid 1..8 |
| req_stage | input | 2 | Stage number, valid 1..2 |
| req_qdb | input | 8 | Attenuation in quarter-dB |
| busy | output | 1 | Write in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 00 ok, 01 bad index, 10 out of range; valid with `done` |
| ser_data | output | 1 | Shared serial data |
| ser_clk | output | 1 | Shared shift clock |
| latch_en | output | 16 | Per-stage latch strobes, index (chan-1)*2+(stage-1) |

## Verification
Several properties are checked on every cycle:
- no more than one latch strobe is high at a time;
- no strobe is high while the shift clock is high or while `busy` is low;
- the data line is steady through every clock high phase;
- every clock-high and strobe-high run lasts at least MIN_CYC clocks;
- a rejected request leaves the serial pins idle.

Other behaviour only the bench scenarios can show: the exact bit pattern and its order, the forced half-dB bit, the exact phase length for a given `div_cfg`, which stage is strobed, the error precedence, and the dropping of a request offered while busy.

// File: rtl/atten_pkg.sv
package atten_pkg;

    localparam int WORD_W = 6;     // code width sent to the device
    localparam int MAX_DB = 31;    // largest whole-dB value accepted

    typedef enum logic [1:0] {
        ERR_NONE  = 2'b00,
        ERR_NODEV = 2'b01,
        ERR_RANGE = 2'b10
    } err_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_CLKHI,
        SQ_GAP,
        SQ_LATCH
    } seq_e;

endpackage

// File: rtl/atten_req_check.sv
module atten_req_check
    import atten_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int NUM_ST = 2,
    parameter int CH_W   = 4,
    parameter int ST_W   = 2,
    parameter int QDB_W  = 8,
    parameter int SEL_W  = 4
) (
    input  logic [CH_W-1:0]   chan,
    input  logic [ST_W-1:0]   stage,
    input  logic [QDB_W-1:0]  qdb,
    output err_e              err,
    output logic [WORD_W-1:0] word,
    output logic [SEL_W-1:0]  sel
);
    logic [QDB_W-1:0] whole_db;
    logic             dev_bad;
    logic             range_bad;
    int               sel_full;

    always_comb begin
        whole_db  = qdb >> 2;
        dev_bad   = (chan == '0) || (int'(chan) > NUM_CH) ||
                    (stage == '0) || (int'(stage) > NUM_ST);
        range_bad = (int'(whole_db) > MAX_DB);
        // half-dB bit is forced to zero; upper bits carry whole dB
        word      = {whole_db[WORD_W-2:0], 1'b0};
        sel_full  = (int'(chan) - 1) * NUM_ST + int'(stage) - 1;
        sel       = sel_full[SEL_W-1:0];
        if (dev_bad)        err = ERR_NODEV;
        else if (range_bad) err = ERR_RANGE;
        else                err = ERR_NONE;
    end
endmodule

// File: rtl/atten_le_decode.sv
module atten_le_decode #(
    parameter int NUM_LE = 16,
    parameter int SEL_W  = 4
) (
    input  logic              en,
    input  logic [SEL_W-1:0]  sel,
    output logic [NUM_LE-1:0] le
);
    for (genvar gi = 0; gi < NUM_LE; gi++) begin : g_le
        assign le[gi] = en && (sel == SEL_W'(gi));
    end
endmodule

// File: rtl/atten_loader.sv
module atten_loader
    import atten_pkg::*;
#(
    parameter int NUM_CH       = 8,
    parameter int NUM_ST       = 2,
    parameter int QDB_W        = 8,
    parameter int DIV_W        = 8,
    parameter int CLK_PERIOD_PS = 4000,
    parameter int MIN_PULSE_PS  = 30000,
    localparam int NUM_LE  = NUM_CH * NUM_ST,
    localparam int CH_W    = $clog2(NUM_CH + 1),
    localparam int ST_W    = $clog2(NUM_ST + 1),
    localparam int SEL_W   = (NUM_LE > 1) ? $clog2(NUM_LE) : 1,
    localparam int BIT_W   = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_cfg,
    input  logic              req_valid,
    input  logic [CH_W-1:0]   req_chan,
    input  logic [ST_W-1:0]   req_stage,
    input  logic [QDB_W-1:0]  req_qdb,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err_code,
    output logic              ser_data,
    output logic              ser_clk,
    output logic [NUM_LE-1:0] latch_en
);
    localparam int MIN_RAW = (MIN_PULSE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int MIN_CYC = (MIN_RAW < 1) ? 1 : MIN_RAW;
    localparam logic [DIV_W-1:0] MIN_CNT = DIV_W'(MIN_CYC);

    typedef struct packed {
        seq_e              st;
        logic [DIV_W-1:0]  cnt;
        logic [DIV_W-1:0]  plen;
        logic [BIT_W-1:0]  bitn;
        logic [WORD_W-1:0] word;
        logic [SEL_W-1:0]  sel;
        logic              sclk;
        logic              sdat;
        logic              le_on;
        logic              busy;
        logic              done;
        err_e              err;
    } regs_t;

    regs_t r_q, r_d;

    err_e              chk_err;
    logic [WORD_W-1:0] chk_word;
    logic [SEL_W-1:0]  chk_sel;
    logic [DIV_W-1:0]  plen_req;

    atten_req_check #(
        .NUM_CH(NUM_CH), .NUM_ST(NUM_ST), .CH_W(CH_W), .ST_W(ST_W),
        .QDB_W(QDB_W), .SEL_W(SEL_W)
    ) i_check (
        .chan (req_chan),
        .stage(req_stage),
        .qdb  (req_qdb),
        .err  (chk_err),
        .word (chk_word),
        .sel  (chk_sel)
    );

    atten_le_decode #(.NUM_LE(NUM_LE), .SEL_W(SEL_W)) i_decode (
        .en (r_q.le_on),
        .sel(r_q.sel),
        .le (latch_en)
    );

    assign plen_req = (div_cfg < MIN_CNT) ? MIN_CNT : div_cfg;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.cnt  = (r_q.cnt != '0) ? r_q.cnt - 1'b1 : r_q.cnt;
        unique case (r_q.st)
            SQ_IDLE: begin
                if (req_valid) begin
                    r_d.err = chk_err;
                    if (chk_err != ERR_NONE) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st   = SQ_SETUP;
                        r_d.busy = 1'b1;
                        r_d.plen = plen_req;
                        r_d.cnt  = plen_req - 1'b1;
                        r_d.word = chk_word;
                        r_d.sel  = chk_sel;
                        r_d.bitn = BIT_W'(WORD_W - 1);
                        r_d.sdat = chk_word[WORD_W-1];
                    end
                end
            end
            SQ_SETUP: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = SQ_CLKHI;
                    r_d.sclk = 1'b1;
                    r_d.cnt  = r_q.plen - 1'b1;
                end
            end
            SQ_CLKHI: begin
                if (r_q.cnt == '0) begin
                    r_d.sclk = 1'b0;
                    r_d.cnt  = r_q.plen - 1'b1;
                    if (r_q.bitn == '0) begin
                        r_d.st   = SQ_GAP;
                        r_d.sdat = 1'b0;
                    end else begin
                        r_d.st   = SQ_SETUP;
                        r_d.bitn = r_q.bitn - 1'b1;
                        r_d.sdat = r_q.word[r_q.bitn - 1'b1];
                    end
                end
            end
            SQ_GAP: begin
                if (r_q.cnt == '0) begin
                    r_d.st    = SQ_LATCH;
                    r_d.le_on = 1'b1;
                    r_d.cnt   = r_q.plen - 1'b1;
                end
            end
            SQ_LATCH: begin
                if (r_q.cnt == '0) begin
                    r_d.st    = SQ_IDLE;
                    r_d.le_on = 1'b0;
                    r_d.busy  = 1'b0;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: SQ_IDLE, err: ERR_NONE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = r_q.busy;
    assign done     = r_q.done;
    assign err_code = r_q.err;
    assign ser_data = r_q.sdat;
    assign ser_clk  = r_q.sclk;
endmodule

// File: rtl/atten_loader_chk.sv
module atten_loader_chk #(
    parameter int NUM_LE  = 16,
    parameter int MIN_CYC = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_clk,
    input logic              ser_data,
    input logic [NUM_LE-1:0] latch_en,
    input logic              busy,
    input logic              done,
    input logic [1:0]        err_code
);
    logic [15:0] hi_cnt;
    logic [15:0] le_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            le_cnt <= '0;
        end else begin
            hi_cnt <= ser_clk ? ((hi_cnt == 16'hffff) ? hi_cnt : hi_cnt + 1'b1) : '0;
            le_cnt <= (latch_en != '0) ? ((le_cnt == 16'hffff) ? le_cnt : le_cnt + 1'b1) : '0;
        end
    end

    assert_le_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(latch_en));

    assert_le_quiet_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> (latch_en == '0));

    assert_le_needs_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en != '0) |-> busy);

    assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    assert_clk_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_clk) |-> (int'(hi_cnt) >= MIN_CYC));

    assert_le_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((latch_en == '0) && ($past(latch_en) != '0)) |-> (int'(le_cnt) >= MIN_CYC));

    assert_reject_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (err_code != 2'b00)) |-> (!busy && !ser_clk && (latch_en == '0)));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && (latch_en == '0)));
endmodule

bind atten_loader atten_loader_chk #(
    .NUM_LE (NUM_LE),
    .MIN_CYC(MIN_CYC)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_clk (ser_clk),
    .ser_data(ser_data),
    .latch_en(latch_en),
    .busy    (busy),
    .done    (done),
    .err_code(err_code)
);

// File: tb/test_atten_loader.sv
`timescale 1ns/1ps
module test_atten_loader;
    localparam int MINC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  div_cfg = '0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_chan = '0;
    logic [1:0]  req_stage = '0;
    logic [7:0]  req_qdb = '0;
    logic        busy, done, ser_data, ser_clk;
    logic [1:0]  err_code;
    logic [15:0] latch_en;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    atten_loader i_atten_loader (
        .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .req_valid(req_valid),
        .req_chan(req_chan), .req_stage(req_stage), .req_qdb(req_qdb),
        .busy(busy), .done(done), .err_code(err_code), .ser_data(ser_data),
        .ser_clk(ser_clk), .latch_en(latch_en)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_err(int ch, int st, int q);
        if (ch == 0 || ch > 8 || st == 0 || st > 2) return 1;
        if (q / 4 > 31) return 2;
        return 0;
    endfunction

    function automatic int exp_word(int q);
        return ((q / 4) * 2) & 63;
    endfunction

    function automatic int exp_le(int ch, int st);
        return 1 << ((ch - 1) * 2 + st - 1);
    endfunction

    function automatic int exp_p(int d);
        return (d < MINC) ? MINC : d;
    endfunction

    task automatic run_req(input int ch, input int st, input int q, input int d, input bit inject);
        int e, p, rises, word, hi_run, hi_min, hi_max, lo_first, le_val, le_w, le_pulses;
        int bad_hold, bad_busy, cyc, done_at, extra_done, extra_act;
        logic prev_clk, prev_le, rise_dat;
        e = exp_err(ch, st, q);
        p = exp_p(d);
        @(negedge clk);
        req_chan = 4'(ch); req_stage = 2'(st); req_qdb = 8'(q); div_cfg = 8'(d);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rises = 0; word = 0; hi_run = 0; hi_min = 9999; hi_max = 0; lo_first = 0;
        le_val = 0; le_w = 0; le_pulses = 0; bad_hold = 0; bad_busy = 0;
        done_at = -1; extra_done = 0; extra_act = 0;
        prev_clk = 1'b0; prev_le = 1'b0; rise_dat = 1'b0;
        for (cyc = 0; cyc < 20 * p + 60; cyc++) begin
            if (cyc > 0) @(negedge clk);
            if (inject && cyc == 5) begin
                req_chan = 4'(ch == 8 ? 1 : ch + 1); req_stage = 2'(st); req_qdb = 8'd40;
                req_valid = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
            if (ser_clk && !prev_clk) begin
                rises++;
                word = (word << 1) | int'(ser_data);
                rise_dat = ser_data;
                hi_run = 0;
            end
            if (ser_clk) begin
                hi_run++;
                if (ser_data !== rise_dat) bad_hold++;
            end
            if (!ser_clk && prev_clk) begin
                if (hi_run < hi_min) hi_min = hi_run;
                if (hi_run > hi_max) hi_max = hi_run;
            end
            if (rises == 0 && !ser_clk && e == 0) lo_first++;
            if (latch_en != '0) begin
                if (!prev_le) le_pulses++;
                le_val = le_val | int'(latch_en);
                le_w++;
                if (!busy || ser_clk) bad_busy++;
            end
            prev_clk = ser_clk;
            prev_le  = (latch_en != '0);
            if (done) begin
                done_at = cyc;
                break;
            end
        end
        req_valid = 1'b0;
        check(done_at >= 0, "R9 done seen", done_at, 0);
        check(int'(err_code) == e, "R6/R7 err_code", int'(err_code), e);
        check(!busy, "R9 busy low at done", int'(busy), 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (done) extra_done++;
            if (ser_clk || latch_en != '0 || busy) extra_act++;
        end
        check(extra_done == 0, "R9 single done pulse", extra_done, 0);
        check(extra_act == 0, "R8 no activity after done", extra_act, 0);
        if (e != 0) begin
            check(done_at == 0, "R6 reject one cycle after request", done_at, 0);
            check(rises == 0 && le_pulses == 0, "R6 no pulses on reject", rises + le_pulses, 0);
        end else begin
            check(rises == 6, "R3 six clock rises", rises, 6);
            check(word == exp_word(q), "R2 shifted code", word, exp_word(q));
            check(lo_first == p, "R4 setup phase length", lo_first, p);
            check(hi_min == p && hi_max == p, "R4 clock high length", hi_max, p);
            check(bad_hold == 0, "R3 data held while clock high", bad_hold, 0);
            check(le_pulses == 1, "R5 one latch pulse", le_pulses, 1);
            check(le_val == exp_le(ch, st), "R5 latch index", le_val, exp_le(ch, st));
            check(le_w == p, "R4 latch width", le_w, p);
            check(bad_busy == 0, "R8 latch inside busy", bad_busy, 0);
        end
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        check(!ser_data && !ser_clk && latch_en == '0 && !busy && !done,
              "R1 outputs low in reset", int'(latch_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(!ser_data && !ser_clk && latch_en == '0 && !busy && !done,
              "R1 outputs low after reset", int'(latch_en), 0);

        // directed corners
        run_req(1, 1, 0, 0, 1'b0);      // R2 zero code, R4 floor
        run_req(8, 2, 124, 12, 1'b0);   // R5 top index, R4 divider above floor
        run_req(3, 2, 127, 3, 1'b0);    // R7 boundary accepted
        run_req(2, 1, 6, 9, 1'b0);      // R2 half-dB bit forced to zero
        run_req(4, 1, 128, 0, 1'b0);    // R7 range error
        run_req(0, 1, 40, 0, 1'b0);     // R6 channel zero
        run_req(9, 1, 40, 0, 1'b0);     // R6 channel too high
        run_req(5, 0, 40, 0, 1'b0);     // R6 stage zero
        run_req(5, 3, 40, 0, 1'b0);     // R6 stage too high
        run_req(0, 1, 200, 0, 1'b0);    // R7 precedence of index error
        run_req(6, 2, 84, 10, 1'b1);    // R8 request while busy ignored

        // constrained random
        for (int i = 0; i < 40; i++) begin
            int ch, st, q, d;
            ch = int'($urandom_range(0, 9));
            st = int'($urandom_range(0, 3));
            q  = int'($urandom_range(0, 140));
            d  = int'($urandom_range(0, 16));
            run_req(ch, st, q, d, ($urandom_range(0, 3) == 0));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule